// File: doc/BRIEF.md
# Temperature Threshold Event and Interrupt Controller

This block watches one on-chip temperature sensor channel. The sensor model presents a 12-bit raw code with a valid strobe. The raw code grows as the die gets hotter. The block keeps the most recent accepted code and compares each new code with three programmable threshold codes. Whenever a code moves from below a threshold to at or above it, the block records an upward event for that threshold. Whenever a code moves from at or above a threshold to below it, the block records a downward event. Events collect in a sticky status register. Two gating registers, an enable and a mask, decide which pending events drive the single interrupt line.

Software programs the block through a flat 32-bit register port. Writes take effect at a clock edge and reads are combinational. A control register holds a power-down bit and a run bit. After reset the power-down bit is set, and the sensor is not sampled until software clears the power-down bit and sets the run bit. A two-bit calibration field from the fuse side is visible through the port, and a separate output is high when both bits are set.

A small state machine tracks the sampling phase. The states are OFF (power-down bit set), HALT (powered but run bit clear), PRIME (running, with no earlier sample to compare against) and RUN (running, with an earlier sample held). Every state goes to OFF when the power-down bit is set. Otherwise a state goes to HALT when the run bit is clear. OFF, HALT and PRIME go to RUN on an accepted sample and to PRIME when no sample arrives. RUN stays in RUN.

Top module: `thsx_ctrl`

## Requirements
- R1: After reset, the control register at offset 0x20 reads 0x40 (power-down bit 6 set, run bit 0 clear). The status, mask, enable, threshold and code registers read 0, and `irq` is low.
- R2: The port decodes these offsets. 0x04 is status, 0x08 is mask, 0x10 is enable, 0x14, 0x18 and 0x1C are thresholds 1 to 3 (bits 11:0), 0x20 is control (bits 6 and 0), 0x28 is the current code (bits 11:0) and 0x68 is calibration. Status, mask and enable use bits 5:0. Bits that are not implemented read 0, and offset 0x0C and any unlisted offset read 0.
- R3: A sample is accepted only when `smp_valid` is high, the power-down bit is 0 and the run bit is 1. All other samples leave every register unchanged.
- R4: Each accepted sample is written to the code register and can be read at 0x28 right after the clock edge that accepts it.
- R5: The first sample accepted after leaving OFF or HALT only loads the code register and raises no event. Clearing the run bit discards the earlier sample.
- R6: An upward event for threshold k (status bit k-1, bits 0 to 2) is set when the held code is below threshold k and the new accepted code is at or above it.
- R7: A downward event for threshold k (status bit k+2, bits 3 to 5) is set when the held code is at or above threshold k and the new accepted code is below it. A single sample never sets both the upward and the downward event of one threshold.
- R8: Events latch into status whatever the enable and mask values are. A status bit stays set until software clears it.
- R9: A write to status clears every bit written as 0, so writing 0 clears all pending events. An event that arrives in the same cycle as the write is still recorded.
- R10: `irq` is high exactly when status AND enable AND mask is nonzero, and it follows status in the same cycle.
- R11: Offset 0x68 bits 15:14 show `cal_bits`. `cal_ok` is high only when both bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| smp_valid | input | 1 | Sensor code strobe |
| smp_code | input | 12 | Raw sensor code |
| cal_bits | input | 2 | Calibration-valid field |
| cal_ok | output | 1 | Both calibration bits set |
| irq | output | 1 | Interrupt request |

## Verification
An error in the held code or in the sampling phase appears on the register port at the clock edge after the faulty sample. It shows either as a wrong value read at 0x28 or as a status bit that is wrong or missing. A status or gating error reaches `irq` in the same cycle. Because of this, the bench compares `irq`, `cal_ok` and the word at the current read address with a behavioural model on every clock. A fault that exists only in the PRIME and RUN handling shows up on the first sample after a restart.

// File: rtl/thsx_pkg.sv
package thsx_pkg;
    localparam int OFF_STAT  = 'h04;
    localparam int OFF_MASK  = 'h08;
    localparam int OFF_EN    = 'h10;
    localparam int OFF_THR0  = 'h14;
    localparam int OFF_CTRL  = 'h20;
    localparam int OFF_CODE  = 'h28;
    localparam int OFF_CAL   = 'h68;
    localparam int PON_BIT   = 6;
    localparam int RUN_BIT   = 0;
    localparam int CAL_LSB   = 14;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_HALT,
        ST_PRIME,
        ST_RUN
    } sens_state_t;
endpackage

// File: rtl/thsx_seq.sv
module thsx_seq
    import thsx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_pon,
    input  logic        ctrl_run,
    input  logic        smp_valid,
    output logic        accept,
    output logic        armed,
    output sens_state_t state
);
    sens_state_t state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF, ST_HALT, ST_PRIME: begin
                if (ctrl_pon)       state_nx = ST_OFF;
                else if (!ctrl_run) state_nx = ST_HALT;
                else if (smp_valid) state_nx = ST_RUN;
                else                state_nx = ST_PRIME;
            end
            ST_RUN: begin
                if (ctrl_pon)       state_nx = ST_OFF;
                else if (!ctrl_run) state_nx = ST_HALT;
                else                state_nx = ST_RUN;
            end
        endcase
    end

    // outputs
    always_comb begin
        accept = smp_valid && !ctrl_pon && ctrl_run;
        armed  = (state == ST_RUN);
    end
endmodule

// File: rtl/thsx_cross.sv
module thsx_cross #(
    parameter int CODE_W  = 12,
    parameter int NUM_THR = 3
) (
    input  logic [CODE_W-1:0]         prev_code,
    input  logic [CODE_W-1:0]         new_code,
    input  logic [NUM_THR*CODE_W-1:0] thr_flat,
    input  logic                      accept,
    input  logic                      armed,
    output logic [NUM_THR-1:0]        rise_evt,
    output logic [NUM_THR-1:0]        fall_evt
);
    for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
        logic [CODE_W-1:0] lvl;
        logic              was_above;
        logic              now_above;
        assign lvl       = thr_flat[g*CODE_W +: CODE_W];
        assign was_above = (prev_code >= lvl);
        assign now_above = (new_code  >= lvl);
        assign rise_evt[g] = accept && armed && !was_above &&  now_above;
        assign fall_evt[g] = accept && armed &&  was_above && !now_above;
    end
endmodule

// File: rtl/thsx_regs.sv
module thsx_regs
    import thsx_pkg::*;
#(
    parameter int CODE_W  = 12,
    parameter int NUM_THR = 3,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    localparam int EVT_W  = 2 * NUM_THR
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_wr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic [CODE_W-1:0]         smp_code,
    input  logic                      accept,
    input  logic [NUM_THR-1:0]        rise_evt,
    input  logic [NUM_THR-1:0]        fall_evt,
    input  logic [1:0]                cal_bits,
    output logic                      ctrl_pon,
    output logic                      ctrl_run,
    output logic [CODE_W-1:0]         cur_code,
    output logic [NUM_THR*CODE_W-1:0] thr_flat,
    output logic [EVT_W-1:0]          status_vec,
    output logic                      irq
);
    logic [CODE_W-1:0] thr_q [NUM_THR];
    logic [EVT_W-1:0]  mask_q, en_q;
    logic              hit_stat, hit_mask, hit_en, hit_ctrl;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata;
    assign hit_stat = bus_wr && (bus_addr == ADDR_W'(OFF_STAT));
    assign hit_mask = bus_wr && (bus_addr == ADDR_W'(OFF_MASK));
    assign hit_en   = bus_wr && (bus_addr == ADDR_W'(OFF_EN));
    assign hit_ctrl = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_pon <= 1'b1;
            ctrl_run <= 1'b0;
            mask_q   <= '0;
            en_q     <= '0;
        end else begin
            if (hit_ctrl) begin
                ctrl_pon <= bus_wdata[PON_BIT];
                ctrl_run <= bus_wdata[RUN_BIT];
            end
            if (hit_mask) mask_q <= bus_wdata[EVT_W-1:0];
            if (hit_en)   en_q   <= bus_wdata[EVT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_THR; i++) thr_q[i] <= '0;
        end else if (bus_wr) begin
            for (int i = 0; i < NUM_THR; i++)
                if (bus_addr == ADDR_W'(OFF_THR0 + 4 * i))
                    thr_q[i] <= bus_wdata[CODE_W-1:0];
        end
    end

    for (genvar g = 0; g < NUM_THR; g++) begin : g_flat
        assign thr_flat[g*CODE_W +: CODE_W] = thr_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cur_code <= '0;
        else if (accept) cur_code <= smp_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_vec <= '0;
        else status_vec <= (hit_stat ? (status_vec & bus_wdata[EVT_W-1:0]) : status_vec)
                           | {fall_evt, rise_evt};
    end

    assign irq = |(status_vec & en_q & mask_q);

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_STAT))      bus_rdata[EVT_W-1:0] = status_vec;
        else if (bus_addr == ADDR_W'(OFF_MASK)) bus_rdata[EVT_W-1:0] = mask_q;
        else if (bus_addr == ADDR_W'(OFF_EN))   bus_rdata[EVT_W-1:0] = en_q;
        else if (bus_addr == ADDR_W'(OFF_CTRL)) begin
            bus_rdata[PON_BIT] = ctrl_pon;
            bus_rdata[RUN_BIT] = ctrl_run;
        end
        else if (bus_addr == ADDR_W'(OFF_CODE)) bus_rdata[CODE_W-1:0] = cur_code;
        else if (bus_addr == ADDR_W'(OFF_CAL))  bus_rdata[CAL_LSB +: 2] = cal_bits;
        for (int i = 0; i < NUM_THR; i++)
            if (bus_addr == ADDR_W'(OFF_THR0 + 4 * i))
                bus_rdata[CODE_W-1:0] = thr_q[i];
    end
endmodule

// File: rtl/thsx_ctrl.sv
module thsx_ctrl
    import thsx_pkg::*;
#(
    parameter int CODE_W  = 12,
    parameter int NUM_THR = 3,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              smp_valid,
    input  logic [CODE_W-1:0] smp_code,
    input  logic [1:0]        cal_bits,
    output logic              cal_ok,
    output logic              irq
);
    localparam int EVT_W = 2 * NUM_THR;

    logic                      ctrl_pon, ctrl_run, accept, armed;
    sens_state_t               state;
    logic [CODE_W-1:0]         cur_code;
    logic [NUM_THR*CODE_W-1:0] thr_flat;
    logic [NUM_THR-1:0]        rise_evt, fall_evt;
    logic [EVT_W-1:0]          status_vec;

    assign cal_ok = &cal_bits;

    thsx_seq u_seq (
        .clk(clk), .rst_n(rst_n), .ctrl_pon(ctrl_pon), .ctrl_run(ctrl_run),
        .smp_valid(smp_valid), .accept(accept), .armed(armed), .state(state)
    );

    thsx_cross #(.CODE_W(CODE_W), .NUM_THR(NUM_THR)) u_cross (
        .prev_code(cur_code), .new_code(smp_code), .thr_flat(thr_flat),
        .accept(accept), .armed(armed), .rise_evt(rise_evt), .fall_evt(fall_evt)
    );

    thsx_regs #(.CODE_W(CODE_W), .NUM_THR(NUM_THR), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smp_code(smp_code),
        .accept(accept), .rise_evt(rise_evt), .fall_evt(fall_evt),
        .cal_bits(cal_bits), .ctrl_pon(ctrl_pon), .ctrl_run(ctrl_run),
        .cur_code(cur_code), .thr_flat(thr_flat), .status_vec(status_vec), .irq(irq)
    );
endmodule

// File: rtl/thsx_ctrl_chk.sv
module thsx_ctrl_chk #(
    parameter int CODE_W  = 12,
    parameter int NUM_THR = 3,
    parameter int ADDR_W  = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  bus_wr,
    input logic                  ctrl_pon,
    input logic                  ctrl_run,
    input logic [CODE_W-1:0]     cur_code,
    input logic [NUM_THR-1:0]    rise_evt,
    input logic [NUM_THR-1:0]    fall_evt,
    input logic [2*NUM_THR-1:0]  status_vec,
    input logic                  irq
);
    logic stat_wr;
    assign stat_wr = bus_wr && (bus_addr == ADDR_W'(thsx_pkg::OFF_STAT));

    assert_code_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_pon |=> $stable(cur_code));

    assert_no_event_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_pon || !ctrl_run) |=> (rise_evt == '0 && fall_evt == '0));

    assert_one_direction_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_evt != '0) |-> ((rise_evt & fall_evt) == '0));

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((status_vec & $past(status_vec)) == $past(status_vec)));

    assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status_vec != '0));
endmodule

bind thsx_ctrl thsx_ctrl_chk #(.CODE_W(CODE_W), .NUM_THR(NUM_THR), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .ctrl_pon(ctrl_pon), .ctrl_run(ctrl_run), .cur_code(cur_code),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .status_vec(status_vec), .irq(irq)
);

// File: tb/thsx_ctrl_test.sv
module thsx_ctrl_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [7:0]  bus_addr = 0;
    logic        bus_wr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        smp_valid = 0;
    logic [11:0] smp_code = 0;
    logic [1:0]  cal_bits = 0;
    logic        cal_ok, irq;

    int total = 0, bad = 0;
    int m_pon = 1, m_run_bit = 0, m_msk = 0, m_en = 0, m_st = 0, m_code = 0;
    int m_thr [3] = '{0, 0, 0};
    bit m_armed = 0;

    always #4 clk = ~clk;

    thsx_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smp_valid(smp_valid),
        .smp_code(smp_code), .cal_bits(cal_bits), .cal_ok(cal_ok), .irq(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int mread(int a);
        case (a)
            'h04: return m_st;
            'h08: return m_msk;
            'h10: return m_en;
            'h14: return m_thr[0];
            'h18: return m_thr[1];
            'h1C: return m_thr[2];
            'h20: return (m_pon << 6) | m_run_bit;
            'h28: return m_code;
            'h68: return int'(cal_bits) << 14;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(int a);
        case (a)
            'h04: return "R8";
            'h28: return "R4";
            'h68: return "R11";
            default: return "R2";
        endcase
    endfunction

    task automatic model_edge();
        int ev = 0;
        int a = int'(bus_addr);
        bit acc = smp_valid && m_pon == 0 && m_run_bit == 1;
        if (!rst_n) begin
            m_pon = 1; m_run_bit = 0; m_msk = 0; m_en = 0; m_st = 0; m_code = 0;
            m_thr = '{0, 0, 0}; m_armed = 0;
            return;
        end
        if (acc && m_armed)
            for (int k = 0; k < 3; k++) begin
                if (m_code < m_thr[k] && int'(smp_code) >= m_thr[k]) ev |= 1 << k;
                if (m_code >= m_thr[k] && int'(smp_code) < m_thr[k]) ev |= 1 << (k + 3);
            end
        m_armed = (m_pon == 0 && m_run_bit == 1) && (m_armed || smp_valid);
        if (acc) m_code = int'(smp_code);
        if (bus_wr) begin
            case (a)
                'h04: m_st &= int'(bus_wdata[5:0]);
                'h08: m_msk = int'(bus_wdata[5:0]);
                'h10: m_en  = int'(bus_wdata[5:0]);
                'h14: m_thr[0] = int'(bus_wdata[11:0]);
                'h18: m_thr[1] = int'(bus_wdata[11:0]);
                'h1C: m_thr[2] = int'(bus_wdata[11:0]);
                'h20: begin m_pon = int'(bus_wdata[6]); m_run_bit = int'(bus_wdata[0]); end
                default: ;
            endcase
        end
        m_st |= ev;
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R10", 32'(irq), 32'((m_st & m_en & m_msk) != 0));
        chk("R11", 32'(cal_ok), 32'(cal_bits == 2'b11));
        chk(tag_of(int'(bus_addr)), bus_rdata, 32'(mread(int'(bus_addr))));
    endtask

    task automatic wr(int a, logic [31:0] d);
        bus_addr = 8'(a); bus_wr = 1; bus_wdata = d;
        tick();
        bus_wr = 0;
    endtask

    task automatic smp(int c);
        smp_valid = 1; smp_code = 12'(c);
        tick();
        smp_valid = 0;
    endtask

    task automatic exp_rd(int a, logic [31:0] e, string tag);
        bus_addr = 8'(a);
        #1;
        chk(tag, bus_rdata, e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset values
        exp_rd('h20, 32'h40, "R1");
        foreach (m_thr[k]) exp_rd('h14 + 4 * k, 0, "R1");
        exp_rd('h04, 0, "R1"); exp_rd('h08, 0, "R1");
        exp_rd('h10, 0, "R1"); exp_rd('h28, 0, "R1");
        chk("R1", 32'(irq), 0);
        // R2 field widths and reserved offsets
        wr('h14, 32'hFFFF_FABC); exp_rd('h14, 32'hABC, "R2");
        wr('h08, 32'hFF);        exp_rd('h08, 32'h3F, "R2");
        wr('h20, 32'hFFFF);      exp_rd('h20, 32'h41, "R2");
        wr('h0C, 32'hFFFF_FFFF); exp_rd('h0C, 0, "R2");
        exp_rd('h30, 0, "R2");
        wr('h20, 32'h40);
        // R3 samples ignored while powered down or not running
        smp('h777); exp_rd('h28, 0, "R3");
        wr('h20, 32'h00);
        smp('h777); exp_rd('h28, 0, "R3");
        // program thresholds and gating
        wr('h14, 'h400); wr('h18, 'h800); wr('h1C, 'hC00);
        wr('h10, 'h3F);  wr('h08, 'h3F);
        wr('h20, 32'h01);
        // R5 first sample primes only
        smp('h900); exp_rd('h28, 'h900, "R4"); exp_rd('h04, 0, "R5");
        smp('hA00); exp_rd('h04, 0, "R6");
        // R6 equal to threshold counts as at-or-above
        smp('hC00); exp_rd('h04, 'h04, "R6"); chk("R10", 32'(irq), 1);
        // R7 falls through all three
        smp('h3FF); exp_rd('h04, 'h3C, "R7");
        // R9 write zero clears all
        wr('h04, 0); exp_rd('h04, 0, "R9"); chk("R10", 32'(irq), 0);
        // R8 latch while masked
        wr('h08, 0); smp('h500); exp_rd('h04, 'h01, "R8"); chk("R10", 32'(irq), 0);
        wr('h08, 'h3F); chk("R10", 32'(irq), 1);
        // R9 event in same cycle as clear survives
        bus_addr = 'h04; bus_wr = 1; bus_wdata = 0; smp_valid = 1; smp_code = 'h900;
        tick();
        bus_wr = 0; smp_valid = 0;
        exp_rd('h04, 'h02, "R9");
        // R9 partial clear
        smp('hC10); exp_rd('h04, 'h06, "R6");
        wr('h04, 'h04); exp_rd('h04, 'h04, "R9");
        // R5 restart discards earlier sample
        wr('h04, 0); wr('h20, 0); wr('h20, 1);
        smp('h100); exp_rd('h28, 'h100, "R4"); exp_rd('h04, 0, "R5");
        smp('h500); exp_rd('h04, 'h01, "R6");
        // R3 no strobe while running
        smp_code = 'h0FF; tick(); exp_rd('h28, 'h500, "R3");
        // R11 calibration field
        for (int c = 0; c < 4; c++) begin
            cal_bits = 2'(c);
            tick();
            exp_rd('h68, 32'(c) << 14, "R11");
            chk("R11", 32'(cal_ok), 32'(c == 3));
        end
        // free-running mixed sequence against the model
        for (int n = 0; n < 200; n++) begin
            smp_valid = (n % 3) != 0;
            smp_code  = 12'((n * 397) % 4096);
            bus_addr  = (n % 2) ? 8'h04 : 8'h28;
            if (n % 17 == 0) begin bus_wr = 1; bus_addr = 8'h04; bus_wdata = 32'(n % 64); end
            if (n == 100) begin bus_wr = 1; bus_addr = 8'h20; bus_wdata = 0; end
            if (n == 103) begin bus_wr = 1; bus_addr = 8'h20; bus_wdata = 1; end
            tick();
            bus_wr = 0;
        end
        smp_valid = 0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule